// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block keeps four segment base registers and turns a (segment, offset) pair into a flat physical address. Each base register is 16 bits wide and holds one of four roles: code, data, extra or stack. A requester picks one of them, gives a 16-bit offset, and says whether the access targets memory or the separate 64K I/O space. For memory, the chosen base is moved up by four bit positions and the offset is added. The sum is cut to 20 bits, which covers a 1-Mbyte space in which every segment spans 64K contiguous bytes. For I/O, segmentation is bypassed and the offset passes through unchanged.

Software-visible loading of the bases uses a simple write port: one register per cycle, chosen by index. The result is registered, so it appears one cycle after the request, together with a flag that tells memory from I/O.

Top module: `seg_addr_gen`

## Requirements
- R1: For a memory request, the output address one cycle later equals (base << 4) + offset, taken modulo 2^20.
- R2: Base 12A4h with offset 0022h yields address 12A62h.
- R3: Any carry out of bit 19 is dropped, so base FFFFh with offset 0010h yields 00000h.
- R4: For an I/O request (`req_io`=1), the output is the offset zero-extended to 20 bits with `addr_io`=1, whatever the selected base holds.
- R5: The select encoding is 0 = code, 1 = data, 2 = extra, 3 = stack. A write changes only the register it selects.
- R6: A write becomes visible to requests from the next cycle on. A request in the same cycle as a write to its own register uses the old value.
- R7: After reset, the code register holds FFFFh and the other three hold 0000h.
- R8: `addr_valid` is high exactly in the cycle after a cycle with `req_valid` high. It is low while reset is held.
- R9: For a memory request, output bits [3:0] equal offset bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_we | input | 1 | Write strobe for a base register |
| seg_wsel | input | 2 | Index of the register to write |
| seg_wdata | input | 16 | New base value |
| req_valid | input | 1 | Address request present |
| req_seg | input | 2 | Index of the base register to use |
| req_offset | input | 16 | Byte offset |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| addr_valid | output | 1 | Result present |
| addr_out | output | 20 | Physical address |
| addr_io | output | 1 | Result targets I/O space |

## Verification
The bench uses the default widths: 16-bit bases and offsets and a 4-bit shift. These give the 20-bit result, so the worked example and the wrap at the top of the 1-Mbyte space can both be reached with literal values. With four registers, every select code is tried. This covers the reset values, write isolation between registers, and the case where a write and a request hit the same register in the same cycle.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W   = 16,
  parameter int OFF_W   = 16,
  parameter int SHIFT   = 4,
  parameter int NUM_SEG = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       seg_we,
  input  logic [$clog2(NUM_SEG)-1:0] seg_wsel,
  input  logic [SEG_W-1:0]           seg_wdata,
  input  logic                       req_valid,
  input  logic [$clog2(NUM_SEG)-1:0] req_seg,
  input  logic [OFF_W-1:0]           req_offset,
  input  logic                       req_io,
  output logic                       addr_valid,
  output logic [SEG_W+SHIFT-1:0]     addr_out,
  output logic                       addr_io
);
  localparam int ADDR_W = SEG_W + SHIFT;

  logic [SEG_W-1:0]  seg_q [NUM_SEG];
  logic [ADDR_W-1:0] mem_addr, io_addr;

  // R5 R6 R7: per-register write, code register resets to all ones
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SEG; i++) begin
      if (!rst_n)
        seg_q[i] <= (i == 0) ? '1 : '0;
      else if (seg_we && seg_wsel == i[$clog2(NUM_SEG)-1:0])
        seg_q[i] <= seg_wdata;
    end
  end

  // R1 R3: carry past the top bit is discarded by the width
  assign mem_addr = {seg_q[req_seg], {SHIFT{1'b0}}} + ADDR_W'(req_offset);
  assign io_addr  = ADDR_W'(req_offset);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      addr_out   <= '0;
      addr_io    <= 1'b0;
    end else begin
      addr_valid <= req_valid;
      if (req_valid) begin
        addr_out <= req_io ? io_addr : mem_addr;
        addr_io  <= req_io;
      end
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (addr_valid == $past(req_valid)));

  // R4
  io_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && $past(rst_n)) |-> (addr_io == $past(req_io)));

  // R4
  io_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_io && $past(rst_n)) |-> (addr_out == ADDR_W'($past(req_offset))));

  // R9
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_io && $past(rst_n)) |-> (addr_out[SHIFT-1:0] == $past(req_offset[SHIFT-1:0])));
endmodule

// File: tb/tb_seg_addr_gen.sv
module tb_seg_addr_gen;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [19:0] addr;
    logic        io;
    string       tag;
  } exp_t;

  logic        clk = 0, rst_n = 0;
  logic        seg_we = 0;
  logic [1:0]  seg_wsel = 0;
  logic [15:0] seg_wdata = 0;
  logic        req_valid = 0;
  logic [1:0]  req_seg = 0;
  logic [15:0] req_offset = 0;
  logic        req_io = 0;
  logic        addr_valid, addr_io;
  logic [19:0] addr_out;

  int   n_cmp = 0, n_bad = 0;
  exp_t q[$];

  seg_addr_gen dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [19:0] mem(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n && addr_valid) begin
      n_cmp++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL R8: unexpected addr_valid, actual %h expected none", addr_out);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (addr_out !== e.addr || addr_io !== e.io) begin
          n_bad++;
          $display("FAIL %s: actual %h/io%b expected %h/io%b", e.tag, addr_out, addr_io, e.addr, e.io);
        end
      end
    end
  end

  task automatic req(input logic [1:0] s, input logic [15:0] o, input logic io,
                     input logic [19:0] e, input string tag);
    exp_t it;
    req_valid = 1; req_seg = s; req_offset = o; req_io = io;
    it.addr = e; it.io = io; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    seg_we = 1; seg_wsel = s; seg_wdata = d;
    @(negedge clk);
    seg_we = 0;
  endtask

  task automatic idle_check();
    req_valid = 0;
    @(negedge clk);
    n_cmp++;
    if (addr_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R8: addr_valid actual %b expected 0", addr_valid);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if (addr_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R8: addr_valid in reset actual %b expected 0", addr_valid);
    end
    rst_n = 1;
    @(negedge clk);
    // R7 reset values
    req(2'd0, 16'h0000, 0, 20'hFFFF0, "R7 code");
    req(2'd1, 16'h0000, 0, 20'h00000, "R7 data");
    req(2'd2, 16'h0000, 0, 20'h00000, "R7 extra");
    req(2'd3, 16'h0000, 0, 20'h00000, "R7 stack");
    // R3 wrap with reset code value
    req(2'd0, 16'h0010, 0, 20'h00000, "R3 wrap");
    req(2'd0, 16'hFFFF, 0, 20'h0FFEF, "R3 wrap max");
    idle_check();
    // R5 writes isolated
    wr(2'd1, 16'h12A4);
    wr(2'd2, 16'h8000);
    wr(2'd3, 16'h0F0F);
    req(2'd1, 16'h0022, 0, 20'h12A62, "R2 example");
    req(2'd2, 16'h1234, 0, mem(16'h8000, 16'h1234), "R5 extra");
    req(2'd3, 16'hABCD, 0, mem(16'h0F0F, 16'hABCD), "R5 stack");
    req(2'd0, 16'h0001, 0, 20'hFFFF1, "R5 code untouched");
    // R1 / R9 patterns
    wr(2'd0, 16'hF000);
    req(2'd0, 16'hFFFF, 0, mem(16'hF000, 16'hFFFF), "R1 top");
    req(2'd2, 16'h000F, 0, mem(16'h8000, 16'h000F), "R9 low bits");
    // R4 I/O ignores segment
    req(2'd0, 16'hBEEF, 1, 20'h0BEEF, "R4 io code");
    req(2'd3, 16'hFFFF, 1, 20'h0FFFF, "R4 io stack");
    // R6 same-cycle write/request sees old value
    seg_we = 1; seg_wsel = 2'd1; seg_wdata = 16'h5555;
    req(2'd1, 16'h0000, 0, 20'h12A40, "R6 old value");
    seg_we = 0;
    req(2'd1, 16'h0000, 0, 20'h55550, "R6 new value");
    // back-to-back mixed
    req(2'd1, 16'h0003, 1, 20'h00003, "R4 io b2b");
    req(2'd1, 16'h0003, 0, 20'h55553, "R1 b2b");
    idle_check();
    repeat (2) @(negedge clk);
    n_cmp++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R8: missing results actual %0d left expected 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule